// File: doc/BRIEF.md
# Glitch-Free Multi-Bank Clock Divider

The block takes one fast source clock and produces three banks (A, B, C) of four divided clock outputs each. Each bank has its own 2-bit ratio code. A shared prescale control either keeps the bank ratios at their base values or doubles them, which acts as a divide-by-2 stage ahead of the banks. The ratios include values that are not powers of two (6, 10, 12, 20, 24). Every output has a 50% duty cycle.

All ratio codes and the prescale control may change at any moment while the clocks run. Each bank takes a new ratio only when its output period ends, so every period it produces has either the old length or the new length, never one in between and never one outside that pair. Two outputs of bank C can be inverted by a control input. An active-low master reset clears every flip-flop and forces every output low. Releasing it restarts all banks together.

Top module: `mbd_clk_div`

## Requirements
- R1: Bank A divides the source clock by 4, 6, 8 or 12 for codes 00, 01, 10, 11 when `pre_sel_i` is 1, and by 8, 12, 16 or 24 for those codes when `pre_sel_i` is 0.
- R2: Bank B divides by 4, 6, 8 or 10 for codes 00..11 when `pre_sel_i` is 1, and by 8, 12, 16 or 20 when `pre_sel_i` is 0.
- R3: Bank C divides by 2, 4, 6 or 8 for codes 00..11 when `pre_sel_i` is 1, and by 4, 8, 12 or 16 when `pre_sel_i` is 0.
- R4: A change of any ratio code or of `pre_sel_i` takes effect only at the start of a new output period, so every completed output period equals either the ratio in force before the change or the ratio after it.
- R5: Each output is high for the first half of its period and low for the second half, with edges on source rising edges.
- R6: Outputs 0 to 3 of banks A and B are identical within their bank, and outputs 0 and 1 of bank C are identical.
- R7: While `inv_c_i` is 1, bank C outputs 2 and 3 are the complement of bank C output 0. While it is 0, they equal output 0.
- R8: While `rst_ni` is 0, every output is 0 at once and without waiting for a clock edge, whatever the value of `inv_c_i`.
- R9: After `rst_ni` rises, the outputs stay low (with `inv_c_i` at 0) until the third source rising edge. At that edge every bank's output rises together and starts its first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low asynchronous master reset and output enable |
| pre_sel_i | input | 1 | 1: base ratios; 0: all ratios doubled |
| sel_a_i | input | 2 | Bank A ratio code |
| sel_b_i | input | 2 | Bank B ratio code |
| sel_c_i | input | 2 | Bank C ratio code |
| inv_c_i | input | 1 | Invert bank C outputs 2 and 3 |
| qa_o | output | 4 | Bank A clock outputs |
| qb_o | output | 4 | Bank B clock outputs |
| qc_o | output | 4 | Bank C clock outputs |

## Verification
The hardest case to reach from the ports is a ratio change that lands at every possible phase of a running period. This includes a change one or two edges before the wrap, where the synchronizer delay decides whether the next period still runs at the old ratio. The stimulus applies each new set of codes after a different delay taken from the vector table, so changes fall at scattered phases against periods of 2 to 24 cycles. Several vectors change the prescale control and all three codes in the same cycle. A monitor measures every completed period and its high time, and accepts a period only if it equals the old or the new ratio.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int MAX_RATIO = 24;
  localparam int CNT_W     = $clog2(MAX_RATIO + 1);
  localparam int SEL_W     = 2;

  // base value is the ratio at pre=1 divided by two; pre=0 doubles it
  function automatic logic [CNT_W-1:0] ratio_of(input int bank,
                                                input logic [SEL_W-1:0] code,
                                                input logic pre);
    logic [2:0] base;
    case (bank)
      0: case (code)
           2'd0: base = 3'd2;
           2'd1: base = 3'd3;
           2'd2: base = 3'd4;
           default: base = 3'd6;
         endcase
      1: case (code)
           2'd0: base = 3'd2;
           2'd1: base = 3'd3;
           2'd2: base = 3'd4;
           default: base = 3'd5;
         endcase
      default: case (code)
           2'd0: base = 3'd1;
           2'd1: base = 3'd2;
           2'd2: base = 3'd3;
           default: base = 3'd4;
         endcase
    endcase
    return pre ? CNT_W'({base, 1'b0}) : CNT_W'({base, 2'b00});
  endfunction
endpackage

// File: rtl/mbd_sync.sv
module mbd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mbd_bank.sv
module mbd_bank
  import mbd_pkg::*;
#(
  parameter int BANK = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] code_i,
  input  logic             pre_i,
  output logic             div_o,
  output logic [CNT_W-1:0] ratio_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] RST_RATIO = ratio_of(BANK, '0, 1'b0);

  logic [CNT_W-1:0] cnt_q, ratio_q, cnt_nxt, half, last;
  logic             out_q, run_q;

  assign cnt_nxt = cnt_q + 1'b1;
  assign half    = ratio_q >> 1;
  assign last    = ratio_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= RST_RATIO;
      out_q   <= 1'b0;
      run_q   <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      out_q <= 1'b0;
      run_q <= 1'b0;
    end else if (!run_q || cnt_q == last) begin
      // period boundary: only place a new ratio is taken
      cnt_q   <= '0;
      ratio_q <= ratio_of(BANK, code_i, pre_i);
      out_q   <= 1'b1;
      run_q   <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      out_q <= cnt_nxt < half;
    end
  end

  assign div_o   = out_q;
  assign ratio_o = ratio_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/mbd_clk_div.sv
module mbd_clk_div
  import mbd_pkg::*;
#(
  parameter int FANOUT      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pre_sel_i,
  input  logic [1:0]        sel_a_i,
  input  logic [1:0]        sel_b_i,
  input  logic [1:0]        sel_c_i,
  input  logic              inv_c_i,
  output logic [FANOUT-1:0] qa_o,
  output logic [FANOUT-1:0] qb_o,
  output logic [FANOUT-1:0] qc_o
);
  localparam int NBANK  = 3;
  localparam int SYNC_W = 1 + NBANK * SEL_W;
  localparam int INV_LO = FANOUT / 2;

  logic [SYNC_W-1:0]            sel_raw, sel_sync;
  logic                         start_ok;
  logic [NBANK-1:0]             div_w;
  logic [NBANK-1:0][CNT_W-1:0]  ratio_w, cnt_w;

  assign sel_raw = {pre_sel_i, sel_c_i, sel_b_i, sel_a_i};

  mbd_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sel_sync_i (
    .clk_i, .rst_ni, .d_i(sel_raw), .q_o(sel_sync)
  );

  // holds banks idle until the select pipeline carries real values
  mbd_sync #(.W(1), .STAGES(SYNC_STAGES)) start_sync_i (
    .clk_i, .rst_ni, .d_i(1'b1), .q_o(start_ok)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    mbd_bank #(.BANK(b)) bank_i (
      .clk_i,
      .rst_ni,
      .en_i   (start_ok),
      .code_i (sel_sync[b*SEL_W +: SEL_W]),
      .pre_i  (sel_sync[SYNC_W-1]),
      .div_o  (div_w[b]),
      .ratio_o(ratio_w[b]),
      .cnt_o  (cnt_w[b])
    );
  end

  for (genvar k = 0; k < FANOUT; k++) begin : g_out
    assign qa_o[k] = rst_ni & div_w[0];
    assign qb_o[k] = rst_ni & div_w[1];
    if (k >= INV_LO) begin : g_inv
      assign qc_o[k] = rst_ni & (div_w[2] ^ inv_c_i);
    end else begin : g_pass
      assign qc_o[k] = rst_ni & div_w[2];
    end
  end
endmodule

// File: rtl/mbd_clk_div_chk.sv
module mbd_clk_div_chk
  import mbd_pkg::*;
#(
  parameter int FANOUT = 4,
  parameter int NBANK  = 3
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        inv_c_i,
  input logic [FANOUT-1:0]           qa_o,
  input logic [FANOUT-1:0]           qb_o,
  input logic [FANOUT-1:0]           qc_o,
  input logic [NBANK-1:0]            div_w,
  input logic [NBANK-1:0][CNT_W-1:0] ratio_w,
  input logic [NBANK-1:0][CNT_W-1:0] cnt_w
);
  always_comb begin
    // R8
    if (!rst_ni) reset_low_chk: assert (qa_o == '0 && qb_o == '0 && qc_o == '0);
    // R7
    if (rst_ni) inv_c_chk: assert (qc_o[FANOUT-1] == (qc_o[0] ^ inv_c_i));
    // R6
    if (rst_ni) fanout_chk: assert (qa_o == {FANOUT{qa_o[0]}} && qb_o == {FANOUT{qb_o[0]}});
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_b
    // R4
    ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ratio_w[b]) |-> cnt_w[b] == '0);
    // R4
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_w[b] < ratio_w[b]);
    // R5
    rise_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(div_w[b]) |-> cnt_w[b] == '0);
    // R5
    fall_at_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(div_w[b]) |-> cnt_w[b] == (ratio_w[b] >> 1));
  end
endmodule

bind mbd_clk_div mbd_clk_div_chk #(.FANOUT(FANOUT), .NBANK(NBANK)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .inv_c_i(inv_c_i),
  .qa_o   (qa_o),
  .qb_o   (qb_o),
  .qc_o   (qc_o),
  .div_w  (div_w),
  .ratio_w(ratio_w),
  .cnt_w  (cnt_w)
);

// File: tb/mbd_clk_div_tb_top.sv
`timescale 1ns/1ps
module mbd_clk_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pre_sel = 1'b1;
  logic [1:0] sel_a = 2'd0, sel_b = 2'd0, sel_c = 2'd0;
  logic       inv_c = 1'b0;
  logic [3:0] qa, qb, qc;

  always #2.5 clk = ~clk;

  mbd_clk_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pre_sel_i(pre_sel),
    .sel_a_i(sel_a), .sel_b_i(sel_b), .sel_c_i(sel_c), .inv_c_i(inv_c),
    .qa_o(qa), .qb_o(qb), .qc_o(qc)
  );

  // ratios from R1..R3: values at pre=1; pre=0 doubles them
  function automatic int exp_ratio(input int bank, input logic [1:0] code, input logic pre);
    int r;
    case (bank)
      0: case (code) 2'd0: r = 4; 2'd1: r = 6; 2'd2: r = 8; default: r = 12; endcase
      1: case (code) 2'd0: r = 4; 2'd1: r = 6; 2'd2: r = 8; default: r = 10; endcase
      default: case (code) 2'd0: r = 2; 2'd1: r = 4; 2'd2: r = 6; default: r = 8; endcase
    endcase
    return pre ? r : 2 * r;
  endfunction

  // {pre, sel_a, sel_b, sel_c, delay before applying}
  localparam int NVEC = 12;
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 2'd1, 2'd2, 2'd3, 4'd0},
    {1'b1, 2'd3, 2'd3, 2'd0, 4'd5},
    {1'b0, 2'd0, 2'd1, 2'd2, 4'd2},
    {1'b0, 2'd3, 2'd3, 2'd3, 4'd7},
    {1'b1, 2'd2, 2'd0, 2'd1, 4'd1},
    {1'b0, 2'd1, 2'd2, 2'd0, 4'd11},
    {1'b0, 2'd2, 2'd0, 2'd1, 4'd4},
    {1'b1, 2'd0, 2'd1, 2'd2, 4'd9},
    {1'b1, 2'd3, 2'd2, 2'd3, 4'd6},
    {1'b0, 2'd0, 2'd3, 2'd0, 4'd13},
    {1'b1, 2'd1, 2'd0, 2'd2, 4'd3},
    {1'b0, 2'd3, 2'd1, 2'd3, 4'd8}
  };

  string rq [3] = '{"R1", "R2", "R3"};

  int n_chk = 0, n_fail = 0;
  int mon_chk = 0, mon_fail = 0;
  int exp_old [3], exp_new [3];
  int since [3], hi [3], hlen [3], last_per [3];
  logic prv [3];
  bit seen [3];

  function automatic logic bank_bit(input int b);
    return (b == 0) ? qa[0] : (b == 1) ? qb[0] : qc[0];
  endfunction

  // period monitor: R4 (old-or-new length), R5 (half high)
  always @(negedge clk) begin
    for (int b = 0; b < 3; b++) begin
      logic cur;
      cur = bank_bit(b);
      if (!rst_n) begin
        seen[b] = 0; prv[b] = 0; since[b] = 0; hi[b] = 0;
      end else begin
        if (cur && !prv[b]) begin
          if (seen[b]) begin
            mon_chk++;
            if (since[b] != exp_old[b] && since[b] != exp_new[b]) begin
              mon_fail++;
              $display("FAIL R4 bank %0d period act=%0d exp=%0d or %0d", b, since[b], exp_old[b], exp_new[b]);
            end
            mon_chk++;
            if (2 * hlen[b] != since[b]) begin
              mon_fail++;
              $display("FAIL R5 bank %0d high act=%0d exp=%0d", b, hlen[b], since[b] / 2);
            end
            last_per[b] = since[b];
          end
          seen[b] = 1; since[b] = 1; hi[b] = 1;
        end else begin
          since[b]++;
          if (cur) hi[b]++;
        end
        if (!cur && prv[b]) hlen[b] = hi[b];
        prv[b] = cur;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic check_startup();
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 low before third edge", {qa, qb, qc}, 0);
    @(negedge clk);
    check("R9 all rise on third edge", {qa, qb, qc}, 12'hfff);
  endtask

  initial begin
    for (int b = 0; b < 3; b++) begin
      exp_old[b] = exp_ratio(b, 2'd0, 1'b1);
      exp_new[b] = exp_old[b];
      last_per[b] = 0;
    end
    repeat (3) @(negedge clk);
    check("R8 reset outputs low", {qa, qb, qc}, 0);
    inv_c = 1'b1;
    #1 check("R8 reset low with invert", {qa, qb, qc}, 0);
    inv_c = 1'b0;
    check_startup();
    repeat (40) @(negedge clk);
    for (int b = 0; b < 3; b++) check(rq[b], last_per[b], exp_new[b]);

    for (int i = 0; i < NVEC; i++) begin
      logic [10:0] v;
      v = VEC[i];
      repeat (int'(v[3:0])) @(negedge clk);
      pre_sel = v[10]; sel_a = v[9:8]; sel_b = v[7:6]; sel_c = v[5:4];
      for (int b = 0; b < 3; b++) begin
        exp_old[b] = exp_new[b];
        exp_new[b] = exp_ratio(b, (b == 0) ? v[9:8] : (b == 1) ? v[7:6] : v[5:4], v[10]);
      end
      repeat (60) @(negedge clk);
      for (int b = 0; b < 3; b++) check(rq[b], last_per[b], exp_new[b]);
      check("R6 bank fanout", {qa == {4{qa[0]}}, qb == {4{qb[0]}}, qc[1] == qc[0]}, 3'b111);
    end

    inv_c = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check("R7 invert high", {qc[3], qc[2]}, {2{~qc[0]}});
    end
    inv_c = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R7 invert low", {qc[3], qc[2]}, {2{qc[0]}});
    end

    inv_c = 1'b1;
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5 check("R8 async reset mid-run", {qa, qb, qc}, 0);
    repeat (2) @(negedge clk);
    inv_c = 1'b0;
    check_startup();
    repeat (60) @(negedge clk);
    for (int b = 0; b < 3; b++) check(rq[b], last_per[b], exp_new[b]);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + mon_chk + 1, n_fail + mon_fail + 1);
    $finish;
  end
endmodule